// File: doc/BRIEF.md
# Coin-Accumulating Vend Release Controller

This controller keeps a running credit from coins dropped into a single slot that takes nickels (5 cents) and dimes (10 cents). Once the credit reaches 15 cents or more, it raises a chute-release output and holds it there until reset. No change is returned, and credit beyond 15 cents is simply discarded. The coin sensors deliver a one-cycle pulse per coin. With no pulse in a cycle, the credit holds.

Two build-time parameters choose the implementation. `OUT_REGISTERED` picks the output style:

- **0:** the output is decoded from the credit state (Moore style).
- **1:** the output comes from a flip-flop loaded from the next-state logic (registered-output style). It rises after the same clock edge at which the Moore version enters its paid state.

`STATE_ONE_HOT` picks the credit state encoding:

- **0:** a 2-bit binary encoding.
- **1:** a 4-bit one-hot encoding.

All four builds behave the same at the ports.

The states are credit-zero (0 cents), credit-five, credit-ten and paid (15 cents). The transitions are:

- **nickel-step:** 0→5, 5→10 and 10→paid.
- **dime-step:** 0→10, 5→paid and 10→paid, the last one saturating.
- **idle-hold:** every state holds when no coin arrives.
- **paid-hold:** paid stays paid on any coin.
- **double-coin:** any state goes to paid.
- **reset:** any state goes to credit-zero.

Top module: `vend_release_ctrl`

## Requirements
- R1: With `rst` high at a rising clock edge, the credit returns to 0 and `chute_open` is low after that edge, whatever the coin inputs are.
- R2: A `nickel` pulse with `dime` low adds 5 cents: 0→5, 5→10, 10→15.
- R3: A `dime` pulse with `nickel` low adds 10 cents and saturates at 15: 0→10, 5→15, 10→15.
- R4: In a cycle with both coin inputs low, the credit is unchanged, so idle gaps between coins do not alter the result.
- R5: `chute_open` is high exactly when the credit is 15 cents. It rises after the clock edge that samples the completing coin.
- R6: Once `chute_open` is high, it stays high on every later cycle until a reset, including when further coins arrive.
- R7: `nickel` and `dime` high in the same cycle is treated as 15 cents of credit and moves any state to paid. No undefined state code is ever reached.
- R8: With `OUT_REGISTERED`=1, `chute_open` shows, cycle for cycle, the same values as the Moore build.
- R9: With `STATE_ONE_HOT`=1, exactly one state bit is set after reset, and the port behaviour is identical to the binary build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel | input | 1 | One-cycle pulse per 5-cent coin |
| dime | input | 1 | One-cycle pulse per 10-cent coin |
| chute_open | output | 1 | Item release, high while 15 cents are held |

## Verification
Every result is due one clock edge after the stimulus that causes it. A coin or reset sampled at rising edge k shows on `chute_open` after edge k, in both output styles and both encodings. The bench drives each input set just after a falling edge and lets exactly one rising edge pass. It advances its credit model at that same edge and compares all four builds at the following falling edge. The directed sequences are nickel×3, nickel-dime, dime-nickel, dime-dime, gapped coins, mid-sequence reset and double coins. A seeded random run follows them, and each check is tagged with the requirement that caused the transition.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int BIN_W = 2;
    localparam int OH_W  = 4;

    typedef enum logic [BIN_W-1:0] {
        CR_ZERO = 2'b00,
        CR_FIVE = 2'b01,
        CR_TEN  = 2'b10,
        CR_PAID = 2'b11
    } credit_t;

    // one-hot bit positions: one per credit amount
    localparam int OH_ZERO = 0;
    localparam int OH_FIVE = 1;
    localparam int OH_TEN  = 2;
    localparam int OH_PAID = 3;
endpackage

// File: rtl/vend_fsm_bin.sv
module vend_fsm_bin
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel,
    input  logic dime,
    output logic paid_now,
    output logic paid_next
);
    credit_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CR_ZERO: begin
                if (nickel && dime)  state_d = CR_PAID;
                else if (dime)       state_d = CR_TEN;
                else if (nickel)     state_d = CR_FIVE;
            end
            CR_FIVE: begin
                if (dime)            state_d = CR_PAID;
                else if (nickel)     state_d = CR_TEN;
            end
            CR_TEN: begin
                if (nickel || dime)  state_d = CR_PAID;
            end
            CR_PAID:                 state_d = CR_PAID;
            default:                 state_d = CR_ZERO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= CR_ZERO;
        else     state_q <= state_d;
    end

    always_comb begin
        paid_now  = (state_q == CR_PAID);
        paid_next = !rst && (state_d == CR_PAID);
    end

    // R4: no coin, no change
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!nickel && !dime) |=> $stable(state_q));
    // R2: nickel from zero lands on five
    a_r2_nickel_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == CR_ZERO && nickel && !dime) |=> (state_q == CR_FIVE));
    // R3: dime from five completes payment
    a_r3_dime_step: assert property (@(posedge clk) disable iff (rst)
        (state_q == CR_FIVE && dime) |=> (state_q == CR_PAID));
endmodule

// File: rtl/vend_fsm_onehot.sv
module vend_fsm_onehot
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel,
    input  logic dime,
    output logic paid_now,
    output logic paid_next
);
    logic [OH_W-1:0] oh_q, oh_d;
    logic idle, only_n, only_d, both;

    always_comb begin
        idle   = !nickel && !dime;
        only_n = nickel && !dime;
        only_d = dime && !nickel;
        both   = nickel && dime;
        oh_d[OH_ZERO] = oh_q[OH_ZERO] && idle;
        oh_d[OH_FIVE] = (oh_q[OH_ZERO] && only_n) || (oh_q[OH_FIVE] && idle);
        oh_d[OH_TEN]  = (oh_q[OH_ZERO] && only_d) || (oh_q[OH_FIVE] && only_n)
                      || (oh_q[OH_TEN] && idle);
        oh_d[OH_PAID] = oh_q[OH_PAID] || both || (oh_q[OH_FIVE] && dime)
                      || (oh_q[OH_TEN] && (nickel || dime));
    end

    always_ff @(posedge clk) begin
        if (rst) oh_q <= OH_W'(1) << OH_ZERO;
        else     oh_q <= oh_d;
    end

    always_comb begin
        paid_now  = oh_q[OH_PAID];
        paid_next = !rst && oh_d[OH_PAID];
    end

    // R9: exactly one state bit is set
    a_r9_onehot_valid: assert property (@(posedge clk) disable iff (rst)
        $countones(oh_q) == 1);
    // R4: idle cycles keep the state
    a_r4_oh_idle_holds: assert property (@(posedge clk) disable iff (rst)
        idle |=> $stable(oh_q));
endmodule

// File: rtl/vend_chute_drive.sv
module vend_chute_drive #(
    parameter bit REGISTERED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic paid_now,
    input  logic paid_next,
    output logic chute
);
    generate
        if (REGISTERED) begin : g_reg
            logic chute_q;
            always_ff @(posedge clk) begin
                chute_q <= !rst && paid_next;
            end
            assign chute = chute_q;
        end else begin : g_moore
            assign chute = paid_now;
        end
    endgenerate

    // R5: a predicted payment is reached on the next edge
    a_r5_paid_next_leads: assert property (@(posedge clk) disable iff (rst)
        paid_next |=> paid_now);
endmodule

// File: rtl/vend_release_ctrl.sv
module vend_release_ctrl #(
    parameter bit OUT_REGISTERED = 1'b0,
    parameter bit STATE_ONE_HOT  = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel,
    input  logic dime,
    output logic chute_open
);
    logic paid_now, paid_next;

    generate
        if (STATE_ONE_HOT) begin : g_oh
            vend_fsm_onehot u_fsm (
                .clk(clk), .rst(rst), .nickel(nickel), .dime(dime),
                .paid_now(paid_now), .paid_next(paid_next));
        end else begin : g_bin
            vend_fsm_bin u_fsm (
                .clk(clk), .rst(rst), .nickel(nickel), .dime(dime),
                .paid_now(paid_now), .paid_next(paid_next));
        end
    endgenerate

    vend_chute_drive #(.REGISTERED(OUT_REGISTERED)) u_drive (
        .clk(clk), .rst(rst), .paid_now(paid_now), .paid_next(paid_next),
        .chute(chute_open));

    // R1: reset closes the chute on the next cycle
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> !chute_open);
    // R6: release is held until reset
    a_r6_paid_sticky: assert property (@(posedge clk) disable iff (rst)
        chute_open |=> chute_open);
    // R7: double coin always pays
    a_r7_double_pays: assert property (@(posedge clk) disable iff (rst)
        (nickel && dime) |=> chute_open);
    // R8: output agrees with the paid state in either style
    a_r8_out_matches_state: assert property (@(posedge clk) disable iff (rst)
        chute_open == paid_now);
endmodule

// File: tb/vend_release_ctrl_bench.sv
module vend_release_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic o_mb, o_rb, o_mo, o_ro;
    int   errors = 0;
    int   checks = 0;
    int   credit = 0;

    always #2.5 clk = ~clk;

    vend_release_ctrl #(.OUT_REGISTERED(1'b0), .STATE_ONE_HOT(1'b0)) u_vend_release_ctrl (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .chute_open(o_mb));
    vend_release_ctrl #(.OUT_REGISTERED(1'b1), .STATE_ONE_HOT(1'b0)) u_vend_reg_bin (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .chute_open(o_rb));
    vend_release_ctrl #(.OUT_REGISTERED(1'b0), .STATE_ONE_HOT(1'b1)) u_vend_moore_oh (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .chute_open(o_mo));
    vend_release_ctrl #(.OUT_REGISTERED(1'b1), .STATE_ONE_HOT(1'b1)) u_vend_reg_oh (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .chute_open(o_ro));

    function automatic int next_credit(int c, bit r, bit n, bit d);
        int s;
        if (r) return 0;
        if (n && d) return 15;
        s = c + (n ? 5 : 0) + (d ? 10 : 0);
        return (s > 15) ? 15 : s;
    endfunction

    function automatic string cause_tag(int c, bit r, bit n, bit d);
        if (r) return "R1";
        if (n && d) return "R7";
        if (c == 15) return "R6";
        if (!n && !d) return "R4";
        if (d) return "R3";
        return "R2";
    endfunction

    task automatic check_one(string tag, string who, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: chute_open=%b expected %b (credit %0d)",
                     tag, who, act, exp, credit);
        end
    endtask

    // drive one input set across one rising edge, then compare at the falling edge
    task automatic step(bit r, bit n, bit d);
        string tag;
        logic  exp;
        tag = cause_tag(credit, r, n, d);
        rst = r; nickel = n; dime = d;
        @(posedge clk);
        credit = next_credit(credit, r, n, d);
        @(negedge clk);
        exp = (credit == 15);
        check_one({tag, "/R5"}, "moore-bin", o_mb, exp);
        check_one({tag, "/R8"}, "reg-bin",   o_rb, exp);
        check_one({tag, "/R9"}, "moore-oh",  o_mo, exp);
        check_one({tag, "/R9"}, "reg-oh",    o_ro, exp);
    endtask

    task automatic do_reset();
        step(1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        @(negedge clk);
        do_reset();                              // R1 reset state
        // nickel x3 (R2)
        step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
        step(0, 1, 0); step(0, 0, 1);            // R6 sticky on more coins
        do_reset();
        // nickel, dime (R3 5->15)
        step(0, 1, 0); step(0, 0, 1);
        do_reset();
        // dime, nickel (R3 then R2 10->15)
        step(0, 0, 1); step(0, 1, 0);
        do_reset();
        // dime, dime saturates (R3)
        step(0, 0, 1); step(0, 0, 1);
        do_reset();
        // gapped coins (R4)
        step(0, 1, 0); step(0, 0, 0); step(0, 0, 0); step(0, 1, 0);
        step(0, 0, 0); step(0, 0, 0); step(0, 1, 0); step(0, 0, 0);
        // mid-sequence reset with a coin present (R1 priority)
        do_reset();
        step(0, 0, 1); step(1, 0, 1); step(0, 1, 0); step(0, 1, 0);
        step(0, 0, 0); step(0, 1, 0);
        // double coin from several states (R7)
        do_reset(); step(0, 1, 1);
        do_reset(); step(0, 1, 0); step(0, 1, 1);
        do_reset(); step(0, 0, 1); step(0, 1, 1);
        // reset releases a paid state (R1)
        do_reset(); step(0, 0, 0);
        // seeded random run
        for (int i = 0; i < 3000; i++) begin
            int unsigned p;
            bit r, n, d;
            p = $urandom_range(99);
            r = (p < 4);
            p = $urandom_range(99);
            n = (p < 25) || (p >= 97);
            d = (p >= 25 && p < 45) || (p >= 97);
            step(r, n, d);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule